// File: doc/BRIEF.md
# Octal DAC Command Decoder with Double-Buffered Channel Registers

This block sits behind a serial port and turns 32-bit command frames into updates of a register bank for eight converter channels. Each channel holds two 16-bit layers. The input layer is the staging value. The output layer is the DAC register, and it drives the channel's code pin. Commands can write the staging layer, promote it to the output layer, or do both for one channel or for all channels. Further commands set a per-channel mask that makes promotion automatic, choose the value that the clear pin forces, and reset the bank from software.

The serial clock, frame-select and data pins are sampled by the system clock through synchronizers. A host therefore has to hold each serial level for several system-clock cycles. A frame counts only when exactly 32 bits arrived while frame-select was low. The hardware load pin promotes every channel at once. The clear pin forces both layers of every channel to the selected clear value.

Top module: `octal_dac_decoder`

## Requirements
- R1: Serial data is shifted in MSB first on each falling edge of `sclk` while `frame_n` is low. When `frame_n` rises, the frame executes only if exactly 32 bits were shifted in since it fell. Shorter or longer frames change nothing.
- R2: Frame layout: bit 31 is a prefix bit and bits 30–28 are ignored. Bits 27–24 hold the command, bits 23–20 the channel address, bits 19–4 the 16-bit data and bits 3–0 the feature field. A frame with bit 31 set changes no state.
- R3: Command 0000 writes the data to the addressed staging register only, and the output is unchanged. Command 0001 copies the addressed staging register into its output register.
- R4: Command 0011 writes the addressed staging register and promotes that channel only. Command 0010 writes the addressed staging register and then promotes all eight channels.
- R5: Address 1111 applies the command to all eight channels. Address n (0–7) selects channel n. Addresses 1000–1110 select no channel, so neither layer changes.
- R6: Command 0101 sets the clear selector from feature bits 1–0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 makes the clear pin ignored. While `clear_n` is low and the selector is not 11, both layers of every channel are forced to the selected value.
- R7: Command 0110 loads an 8-bit mask from frame bits 7–0, where bit n is channel n. A channel whose mask bit is 1 promotes its staging value into its output register on every write to its staging register.
- R8: A falling edge on `load_n` copies every staging register into its output register.
- R9: Command 0111 returns both layers of every channel to zero, the clear selector to 00 and the mask to zero.
- R10: Commands 1010–1111 are reserved. They and the commands outside this block's scope (0100, 1000, 1001) change no state.
- R11: After `rst`, every output code, every staging register and the mask are zero, and the clear selector is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| frame_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load pin, falling edge promotes all channels |
| clear_n | input | 1 | Active-low clear pin |
| dac_code | output | 128 | Output codes, channel n in bits 16n+15..16n |

## Verification
The assertions watch several rules on every cycle. The bit counter never runs past its saturation value. A frame with the prefix bit set, or one carrying a reserved command, leaves both layers untouched. A clear leaves every channel's two layers equal to one common value. A lone load edge copies the staging layer into the outputs, and reset zeroes every output. The bench scenarios show the rules that depend on command history: the staging-only write becomes visible only after a later load, the mask persists between frames, and the clear selector and the software reset affect later traffic. Discarding of frames by length and the handling of invalid addresses are also shown only by the scenarios.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int FRAME_W = 32;
    localparam int NUM_CH  = 8;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int CMD_W   = 4;
    localparam int FEAT_W  = 4;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_STAGE   = 4'h0,
        CMD_PROMOTE    = 4'h1,
        CMD_WR_PROMALL = 4'h2,
        CMD_WR_PROMONE = 4'h3,
        CMD_CLR_SEL    = 4'h5,
        CMD_AUTO_MASK  = 4'h6,
        CMD_SOFT_RST   = 4'h7
    } cmd_e;

    typedef enum logic [1:0] {
        CLR_ZERO   = 2'b00,
        CLR_MID    = 2'b01,
        CLR_FULL   = 2'b10,
        CLR_IGNORE = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic              prefix;
        logic [2:0]        spare;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [FEAT_W-1:0] feat;
    } frame_t;

    typedef struct packed {
        logic [NUM_CH-1:0] wr_stage;
        logic [NUM_CH-1:0] promote;
        logic [DATA_W-1:0] data;
        logic              set_clr;
        clr_sel_e          clr_sel;
        logic              set_mask;
        logic [NUM_CH-1:0] mask;
        logic              soft_rst;
    } action_t;

    function automatic logic [DATA_W-1:0] clear_value(input clr_sel_e sel);
        logic [DATA_W-1:0] v;
        case (sel)
            CLR_MID:  v = {1'b1, {(DATA_W-1){1'b0}}};
            CLR_FULL: v = {DATA_W{1'b1}};
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [NUM_CH-1:0] addr_to_mask(input logic [ADDR_W-1:0] a);
        logic [NUM_CH-1:0] m;
        m = '0;
        if (a == {ADDR_W{1'b1}}) begin
            m = '1;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (int'(a) == i) m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= INIT;
        else     st[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[k] <= INIT;
            else     st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/octdac_frame_rx.sv
module octdac_frame_rx
    import octdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             frame_n_s,
    input  logic             sdi_s,
    output frame_t           frame,
    output logic             frame_vld,
    output logic [CNT_W-1:0] bit_cnt
);
    logic               sclk_d;
    logic               frame_n_d;
    logic [FRAME_W-1:0] shreg;

    wire sclk_fall  = sclk_d & ~sclk_s;
    wire frame_fall = frame_n_d & ~frame_n_s;
    wire frame_rise = ~frame_n_d & frame_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b1;
            frame_n_d <= 1'b1;
            shreg     <= '0;
            bit_cnt   <= '0;
            frame_vld <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            frame_n_d <= frame_n_s;
            frame_vld <= frame_rise && (bit_cnt == CNT_W'(FRAME_W));
            if (frame_fall) begin
                bit_cnt <= '0;
            end else if (!frame_n_s && sclk_fall) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign frame = frame_t'(shreg);
endmodule

// File: rtl/octdac_decode.sv
module octdac_decode
    import octdac_pkg::*;
(
    input  frame_t  frame,
    input  logic    frame_vld,
    output action_t act
);
    logic [FRAME_W-1:0] raw;
    logic [NUM_CH-1:0]  sel;

    assign raw = frame;
    assign sel = addr_to_mask(frame.addr);

    always_comb begin
        act      = '0;
        act.data = frame.data;
        if (frame_vld && !frame.prefix) begin
            case (cmd_e'(frame.cmd))
                CMD_WR_STAGE: act.wr_stage = sel;
                CMD_PROMOTE:  act.promote  = sel;
                CMD_WR_PROMALL: begin
                    act.wr_stage = sel;
                    act.promote  = (sel != '0) ? '1 : '0;
                end
                CMD_WR_PROMONE: begin
                    act.wr_stage = sel;
                    act.promote  = sel;
                end
                CMD_CLR_SEL: begin
                    act.set_clr = 1'b1;
                    act.clr_sel = clr_sel_e'(frame.feat[1:0]);
                end
                CMD_AUTO_MASK: begin
                    act.set_mask = 1'b1;
                    act.mask     = raw[NUM_CH-1:0];
                end
                CMD_SOFT_RST: act.soft_rst = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/octdac_bank.sv
module octdac_bank
    import octdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  action_t                  act,
    input  logic                     ld_fall,
    input  logic                     clr_lvl,
    output logic [NUM_CH*DATA_W-1:0] dac_flat,
    output logic [NUM_CH*DATA_W-1:0] stage_flat,
    output logic                     clr_force
);
    clr_sel_e          clr_sel_q;
    logic [NUM_CH-1:0] mask_q;
    logic [DATA_W-1:0] clr_val;
    logic              wipe;

    assign clr_force = clr_lvl && (clr_sel_q != CLR_IGNORE);
    assign clr_val   = clear_value(clr_sel_q);
    assign wipe      = rst || act.soft_rst;

    always_ff @(posedge clk) begin
        if (wipe) begin
            clr_sel_q <= CLR_ZERO;
            mask_q    <= '0;
        end else begin
            if (act.set_clr)  clr_sel_q <= act.clr_sel;
            if (act.set_mask) mask_q    <= act.mask;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DATA_W-1:0] stage_q;
        logic [DATA_W-1:0] dac_q;
        logic [DATA_W-1:0] stage_n;
        logic              do_promote;

        assign stage_n    = act.wr_stage[i] ? act.data : stage_q;
        assign do_promote = act.promote[i] | ld_fall | (mask_q[i] & act.wr_stage[i]);

        always_ff @(posedge clk) begin
            if (wipe) begin
                stage_q <= '0;
                dac_q   <= '0;
            end else if (clr_force) begin
                stage_q <= clr_val;
                dac_q   <= clr_val;
            end else begin
                stage_q <= stage_n;
                if (do_promote) dac_q <= stage_n;
            end
        end

        assign dac_flat[i*DATA_W +: DATA_W]   = dac_q;
        assign stage_flat[i*DATA_W +: DATA_W] = stage_q;
    end
endmodule

// File: rtl/octal_dac_decoder.sv
module octal_dac_decoder
    import octdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     frame_n,
    input  logic                     sdi,
    input  logic                     load_n,
    input  logic                     clear_n,
    output logic [NUM_CH*DATA_W-1:0] dac_code
);
    localparam int PINS = 5;

    logic [PINS-1:0]          pins_s;
    frame_t                   frame;
    logic [FRAME_W-1:0]       frame_raw;
    logic                     frame_vld;
    logic [CNT_W-1:0]         bit_cnt;
    action_t                  act;
    logic                     load_d;
    logic                     ld_fall;
    logic                     clr_force;
    logic [NUM_CH*DATA_W-1:0] stage_flat;

    octdac_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES),
        .INIT   (5'b11011)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, frame_n, sdi, load_n, clear_n}),
        .q   (pins_s)
    );

    octdac_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[4]),
        .frame_n_s (pins_s[3]),
        .sdi_s     (pins_s[2]),
        .frame     (frame),
        .frame_vld (frame_vld),
        .bit_cnt   (bit_cnt)
    );

    assign frame_raw = frame;

    octdac_decode u_dec (
        .frame     (frame),
        .frame_vld (frame_vld),
        .act       (act)
    );

    always_ff @(posedge clk) begin
        if (rst) load_d <= 1'b1;
        else     load_d <= pins_s[1];
    end
    assign ld_fall = load_d & ~pins_s[1];

    octdac_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .ld_fall    (ld_fall),
        .clr_lvl    (~pins_s[0]),
        .dac_flat   (dac_code),
        .stage_flat (stage_flat),
        .clr_force  (clr_force)
    );
endmodule

// File: rtl/octdac_checker.sv
module octdac_checker
    import octdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*DATA_W-1:0] dac_code,
    input logic [NUM_CH*DATA_W-1:0] stage_flat,
    input logic [FRAME_W-1:0]       frame_raw,
    input logic                     frame_vld,
    input logic                     ld_fall,
    input logic                     clr_force,
    input logic [CNT_W-1:0]         bit_cnt
);
    wire quiet_pins = !ld_fall && !clr_force;
    wire reserved   = frame_raw[27:24] >= 4'hA;

    assert_reset_zero_R11: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && (stage_flat == '0));

    assert_bitcnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(CNT_MAX));

    assert_prefix_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        frame_vld && frame_raw[31] && quiet_pins |=> $stable(dac_code) && $stable(stage_flat));

    assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        frame_vld && reserved && quiet_pins |=> $stable(dac_code) && $stable(stage_flat));

    assert_clear_uniform_R6: assert property (@(posedge clk) disable iff (rst)
        clr_force |=> (dac_code == {NUM_CH{dac_code[DATA_W-1:0]}}) && (stage_flat == dac_code));

    assert_load_copy_R8: assert property (@(posedge clk) disable iff (rst)
        ld_fall && !frame_vld && !clr_force |=> dac_code == $past(stage_flat));
endmodule

bind octal_dac_decoder octdac_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .dac_code   (dac_code),
    .stage_flat (stage_flat),
    .frame_raw  (frame_raw),
    .frame_vld  (frame_vld),
    .ld_fall    (ld_fall),
    .clr_force  (clr_force),
    .bit_cnt    (bit_cnt)
);

// File: tb/octal_dac_decoder_bench.sv
module octal_dac_decoder_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b1;
    logic         frame_n = 1'b1;
    logic         sdi = 1'b0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [127:0] dac_code;

    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    logic [15:0]  exp_dac [8];

    always #4 clk = ~clk;

    octal_dac_decoder u_octal_dac_decoder (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .frame_n  (frame_n),
        .sdi      (sdi),
        .load_n   (load_n),
        .clear_n  (clear_n),
        .dac_code (dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] frm(input logic [3:0] cmd, input logic [3:0] addr,
                                        input logic [15:0] data, input logic [3:0] feat);
        return {1'b0, 3'b000, cmd, addr, data, feat};
    endfunction

    task automatic send_bits(input logic [63:0] v, input int n);
        frame_n = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            tick(4);
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
        end
        tick(4);
        frame_n = 1'b1;
        tick(10);
    endtask

    task automatic send(input logic [31:0] f);
        send_bits({32'h0, f}, 32);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        tick(6);
        load_n = 1'b1;
        tick(6);
    endtask

    task automatic pulse_clear();
        clear_n = 1'b0;
        tick(6);
        clear_n = 1'b1;
        tick(6);
    endtask

    task automatic set_all(input logic [15:0] v);
        for (int c = 0; c < 8; c++) exp_dac[c] = v;
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 8; c++) begin
            checks++;
            if (dac_code[c*16 +: 16] !== exp_dac[c]) begin
                errors++;
                $display("FAIL %s ch%0d: actual=%h expected=%h", req, c,
                         dac_code[c*16 +: 16], exp_dac[c]);
            end
        end
    endtask

    task automatic t_reset();
        set_all(16'h0000);
        check_all("R11 reset state");
    endtask

    task automatic t_stage_then_promote();
        send(frm(4'h0, 4'h2, 16'h1234, 4'h0));
        check_all("R3 staging write hidden");
        send(frm(4'h1, 4'h2, 16'h0000, 4'h0));
        exp_dac[2] = 16'h1234;
        check_all("R3 promote addressed");
    endtask

    task automatic t_write_promote();
        send(frm(4'h3, 4'h5, 16'hABCD, 4'h0));
        exp_dac[5] = 16'hABCD;
        check_all("R4 write and promote one");
        send(frm(4'h0, 4'h0, 16'h1111, 4'h0));
        check_all("R3 second staging write hidden");
        send(frm(4'h2, 4'h1, 16'h2222, 4'h0));
        exp_dac[0] = 16'h1111;
        exp_dac[1] = 16'h2222;
        check_all("R4 write and promote all");
    endtask

    task automatic t_broadcast();
        send(frm(4'h3, 4'hF, 16'h5A5A, 4'h0));
        set_all(16'h5A5A);
        check_all("R5 broadcast");
        send(frm(4'h3, 4'h9, 16'h0F0F, 4'h0));
        check_all("R5 invalid address promote");
        send(frm(4'h0, 4'h8, 16'h0F0F, 4'h0));
        pulse_load();
        check_all("R5 invalid address staging");
    endtask

    task automatic t_prefix();
        send(frm(4'h3, 4'h0, 16'h7777, 4'h0) | 32'h8000_0000);
        check_all("R2 prefix frame");
        pulse_load();
        check_all("R2 prefix frame staging");
    endtask

    task automatic t_length();
        send_bits({32'h0, frm(4'h3, 4'h0, 16'h7777, 4'h0)}, 31);
        check_all("R1 short frame");
        send_bits({31'h0, 1'b1, frm(4'h3, 4'h0, 16'h7777, 4'h0)}, 33);
        check_all("R1 long frame");
        send(frm(4'h3, 4'h0, 16'h7777, 4'h0));
        exp_dac[0] = 16'h7777;
        check_all("R1 exact frame");
    endtask

    task automatic t_load();
        send(frm(4'h0, 4'h4, 16'h4444, 4'h0));
        check_all("R8 before load edge");
        pulse_load();
        exp_dac[4] = 16'h4444;
        check_all("R8 load edge");
    endtask

    task automatic t_mask();
        send(frm(4'h6, 4'h0, 16'h0000, 4'h8));
        send(frm(4'h0, 4'h3, 16'h3333, 4'h0));
        exp_dac[3] = 16'h3333;
        check_all("R7 masked channel follows");
        send(frm(4'h0, 4'h6, 16'h6666, 4'h0));
        check_all("R7 unmasked channel held");
        pulse_load();
        exp_dac[6] = 16'h6666;
        check_all("R8 load after unmasked write");
    endtask

    task automatic t_reserved();
        send(frm(4'hB, 4'hF, 16'h1357, 4'h0));
        send(frm(4'hA, 4'h0, 16'h1357, 4'h0));
        send(frm(4'hF, 4'hF, 16'h1357, 4'h3));
        check_all("R10 reserved commands");
        send(frm(4'h4, 4'hF, 16'h00FF, 4'h3));
        send(frm(4'h8, 4'h0, 16'h0000, 4'h1));
        send(frm(4'h9, 4'h0, 16'h8000, 4'h0));
        check_all("R10 out-of-scope commands");
        pulse_load();
        check_all("R10 staging untouched");
    endtask

    task automatic t_clear();
        pulse_clear();
        set_all(16'h0000);
        check_all("R6 clear zero scale");
        send(frm(4'h5, 4'h0, 16'h0000, 4'h1));
        send(frm(4'h3, 4'hF, 16'h1357, 4'h0));
        set_all(16'h1357);
        check_all("R6 data before midscale clear");
        pulse_clear();
        set_all(16'h8000);
        check_all("R6 clear midscale");
        send(frm(4'h5, 4'h0, 16'h0000, 4'h2));
        pulse_clear();
        set_all(16'hFFFF);
        check_all("R6 clear full scale");
        pulse_load();
        check_all("R6 staging also cleared");
        send(frm(4'h5, 4'h0, 16'h0000, 4'h3));
        send(frm(4'h3, 4'hF, 16'h2468, 4'h0));
        pulse_clear();
        set_all(16'h2468);
        check_all("R6 clear pin ignored");
    endtask

    task automatic t_soft_reset();
        send(frm(4'h7, 4'h0, 16'h0000, 4'h0));
        set_all(16'h0000);
        check_all("R9 outputs zeroed");
        pulse_load();
        check_all("R9 staging zeroed");
        send(frm(4'h3, 4'hF, 16'h1111, 4'h0));
        pulse_clear();
        check_all("R9 clear selector back to zero scale");
        send(frm(4'h0, 4'h3, 16'h3333, 4'h0));
        check_all("R9 mask cleared");
        pulse_load();
        exp_dac[3] = 16'h3333;
        check_all("R9 staging write kept");
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_stage_then_promote();
        t_write_promote();
        t_broadcast();
        t_prefix();
        t_length();
        t_load();
        t_mask();
        t_reserved();
        t_clear();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule